// File: doc/BRIEF.md
# Coarse Counter PWM With Dead-Time Insertion

This block is the synchronous, coarse half of a hybrid digital pulse-width modulator for a two-switch power stage (for example a synchronous buck converter). It runs only on the unshifted reference clock. A free-running period counter is compared against the upper bits of a split duty word to form a high-side timing signal. A separate low-side timing signal is built from the same counter, with a programmable guard interval of whole clock cycles on both sides of every high-side pulse. A later fine-edge stage extends or trims these coarse edges by a fraction of a clock. That stage sits outside this block.

With the default of 5 coarse bits the switching period is 32 reference cycles. The coarse duty value D is the number of whole cycles the high-side signal is active in a period. The guard setting T is the number of cycles both sides stay low after the high side falls and before it rises again. Both values are sampled once per period, at the counter wrap. This keeps every period internally consistent, and a new value needs no multi-step update: it takes effect in full in the very next period. A period-start strobe marks the first cycle of each period so that the fine stage can align with it.

Top module: `dpwm_coarse_core`

## Requirements
- R1: While `rst_n` is low, `hi_coarse`, `lo_coarse` and `period_start` are all 0.
- R2: `period_start` is high for exactly one cycle in every 2^COARSE_W cycles (32 by default). It is first high on the second clock edge after reset is released.
- R3: With latched duty D, `hi_coarse` is high in period positions 0 to D-1 and low otherwise. Position 0 is the cycle in which `period_start` is high, so the high side can only rise together with `period_start`.
- R4: A latched duty of 0 keeps `hi_coarse` low for the whole period.
- R5: `duty_msb` is sampled only at the last position of a period (position 2^COARSE_W-1). A change at any other time does not alter the current period's high-side count.
- R6: With latched guard T, `lo_coarse` is high exactly at positions p with p >= D+T and p+T <= 2^COARSE_W-1. With T = 0 it is therefore the exact complement of `hi_coarse`.
- R7: `hi_coarse` and `lo_coarse` are never high in the same cycle.
- R8: `dead_cycles` is sampled at the same instant as `duty_msb`. A change inside a period does not alter that period's low-side count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unshifted reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_msb | input | COARSE_W | Coarse field of the duty word, in whole clock cycles |
| dead_cycles | input | DEAD_W | Guard interval in whole clock cycles |
| hi_coarse | output | 1 | Coarse high-side timing signal |
| lo_coarse | output | 1 | Coarse low-side timing signal |
| period_start | output | 1 | High in the first cycle of every switching period |

## Verification
The bench drives the duty extremes 0 and 2^COARSE_W-1 and the zero guard, where the low side must become the exact complement. It also drives guards so large that D+T runs past the end of the period. A design that mishandles the wide sum would raise the low side during or right after the high pulse. It also changes the duty and guard inputs in the middle of a period. A design that samples them continuously would shorten or stretch the pulse in that same period, and the per-period pulse tallies catch this. The first period after reset is also checked. An off-by-one in the counter's reset value would shift the period strobe and every edge by one cycle.

// File: rtl/dpwm_coarse_pkg.sv
package dpwm_coarse_pkg;

    // Default geometry: 5 coarse bits give 32 reference cycles per period.
    localparam int DEF_COARSE_W = 5;
    localparam int DEF_DEAD_W   = 4;

    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dpwm_period_counter.sv
module dpwm_period_counter #(
    parameter int COARSE_W = dpwm_coarse_pkg::DEF_COARSE_W,
    parameter int DEAD_W   = dpwm_coarse_pkg::DEF_DEAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] duty_in,
    input  logic [DEAD_W-1:0]   dead_in,
    output logic [COARSE_W-1:0] cnt_o,
    output logic [COARSE_W-1:0] duty_o,
    output logic [DEAD_W-1:0]   dead_o
);

    localparam logic [COARSE_W-1:0] CNT_LAST = '1;
    localparam logic [COARSE_W-1:0] CNT_STEP = COARSE_W'(1);

    typedef struct packed {
        logic [COARSE_W-1:0] cnt;
        logic [COARSE_W-1:0] duty;
        logic [DEAD_W-1:0]   dead;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_STEP;
        // Settings are captured only at the wrap, so each period is consistent.
        if (st_q.cnt == CNT_LAST) begin
            st_d.duty = duty_in;
            st_d.dead = dead_in;
        end
    end

    // The reset count sits on the last position, so the first edge wraps and samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_LAST;
            st_q.duty <= '0;
            st_q.dead <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign duty_o = st_q.duty;
    assign dead_o = st_q.dead;

endmodule

// File: rtl/dpwm_side_gen.sv
module dpwm_side_gen #(
    parameter int COARSE_W = dpwm_coarse_pkg::DEF_COARSE_W,
    parameter int DEAD_W   = dpwm_coarse_pkg::DEF_DEAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] cnt_i,
    input  logic [COARSE_W-1:0] duty_i,
    input  logic [DEAD_W-1:0]   dead_i,
    output logic                hi_o,
    output logic                lo_o,
    output logic                start_o
);

    // Two spare bits so duty + guard and count + guard never wrap.
    localparam int SUM_W = dpwm_coarse_pkg::wider(COARSE_W, DEAD_W) + 2;
    localparam logic [SUM_W-1:0] POS_LAST = SUM_W'((1 << COARSE_W) - 1);

    typedef struct packed {
        logic hi;
        logic lo;
        logic start;
    } side_state_t;

    side_state_t st_d, st_q;

    logic [SUM_W-1:0] cnt_x;
    logic [SUM_W-1:0] duty_x;
    logic [SUM_W-1:0] dead_x;
    logic [SUM_W-1:0] lo_first;
    logic [SUM_W-1:0] tail_pos;
    logic             lo_window;

    always_comb begin
        cnt_x     = SUM_W'(cnt_i);
        duty_x    = SUM_W'(duty_i);
        dead_x    = SUM_W'(dead_i);
        lo_first  = duty_x + dead_x;
        tail_pos  = cnt_x + dead_x;
        lo_window = (cnt_x >= lo_first) && (tail_pos <= POS_LAST);

        st_d       = '0;
        st_d.hi    = (cnt_x < duty_x);
        st_d.lo    = lo_window;
        st_d.start = (cnt_i == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o    = st_q.hi;
    assign lo_o    = st_q.lo;
    assign start_o = st_q.start;

endmodule

// File: rtl/dpwm_coarse_core.sv
module dpwm_coarse_core #(
    parameter int COARSE_W = dpwm_coarse_pkg::DEF_COARSE_W,
    parameter int DEAD_W   = dpwm_coarse_pkg::DEF_DEAD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] duty_msb,
    input  logic [DEAD_W-1:0]   dead_cycles,
    output logic                hi_coarse,
    output logic                lo_coarse,
    output logic                period_start
);

    logic [COARSE_W-1:0] cnt_w;
    logic [COARSE_W-1:0] duty_w;
    logic [DEAD_W-1:0]   dead_w;

    dpwm_period_counter #(
        .COARSE_W(COARSE_W),
        .DEAD_W  (DEAD_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_in(duty_msb),
        .dead_in(dead_cycles),
        .cnt_o  (cnt_w),
        .duty_o (duty_w),
        .dead_o (dead_w)
    );

    dpwm_side_gen #(
        .COARSE_W(COARSE_W),
        .DEAD_W  (DEAD_W)
    ) u_side (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_w),
        .duty_i (duty_w),
        .dead_i (dead_w),
        .hi_o   (hi_coarse),
        .lo_o   (lo_coarse),
        .start_o(period_start)
    );

endmodule

// File: rtl/dpwm_coarse_chk.sv
module dpwm_coarse_chk #(
    parameter int COARSE_W = dpwm_coarse_pkg::DEF_COARSE_W
) (
    input logic clk,
    input logic rst_n,
    input logic hi,
    input logic lo,
    input logic pstart
);

    localparam logic [COARSE_W-1:0] GAP_FULL = '1;

    logic [COARSE_W-1:0] gap_q;
    logic                seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pstart) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + COARSE_W'(1);
        end
    end

    // R7
    never_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi && lo));

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstart && seen_q) |-> (gap_q == GAP_FULL));

    // R2
    period_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && gap_q == GAP_FULL) |-> pstart);

    // R3
    hi_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi) |-> pstart);

    // R3
    hi_fall_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hi) |-> !pstart);

endmodule

bind dpwm_coarse_core dpwm_coarse_chk #(.COARSE_W(COARSE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .hi    (hi_coarse),
    .lo    (lo_coarse),
    .pstart(period_start)
);

// File: tb/dpwm_coarse_core_test.sv
module dpwm_coarse_core_test;

    localparam int CLK_PER  = 10;
    localparam int CW       = 5;
    localparam int DW       = 4;
    localparam int PER_LEN  = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] duty_msb = '0;
    logic [DW-1:0] dead_cycles = '0;
    logic          hi_coarse, lo_coarse, period_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dpwm_coarse_core #(.COARSE_W(CW), .DEAD_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .duty_msb    (duty_msb),
        .dead_cycles (dead_cycles),
        .hi_coarse   (hi_coarse),
        .lo_coarse   (lo_coarse),
        .period_start(period_start)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Expected values from the requirements.
    function automatic bit want_hi(int p, int d);
        return p < d;                                        // R3, R4
    endfunction

    function automatic bit want_lo(int p, int d, int t);
        return (p >= d + t) && (p + t <= PER_LEN - 1);       // R6
    endfunction

    function automatic int lo_count(int d, int t);
        int n = 0;
        for (int p = 0; p < PER_LEN; p++) if (want_lo(p, d, t)) n++;
        return n;
    endfunction

    // Period position and sampled settings, advanced on each edge.
    int m_pos = PER_LEN - 1, m_duty = 0, m_dead = 0;
    bit e_hi = 0, e_lo = 0, e_ps = 0;
    int e_duty = 0, e_dead = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pos <= PER_LEN - 1; m_duty <= 0; m_dead <= 0;
            e_hi <= 0; e_lo <= 0; e_ps <= 0; e_duty <= 0; e_dead <= 0;
        end else begin
            e_hi   <= want_hi(m_pos, m_duty);
            e_lo   <= want_lo(m_pos, m_duty, m_dead);
            e_ps   <= (m_pos == 0);
            e_duty <= m_duty;
            e_dead <= m_dead;
            m_pos  <= (m_pos + 1) % PER_LEN;
            if (m_pos == PER_LEN - 1) begin          // R5, R8: sampled at the wrap
                m_duty <= int'(duty_msb);
                m_dead <= int'(dead_cycles);
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-period tallies.
    bit tally_on = 0;
    int t_hi = 0, t_lo = 0, t_duty = 0, t_dead = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(!hi_coarse && !lo_coarse && !period_start, "R1 reset outputs",
                  {hi_coarse, lo_coarse, period_start}, 0);
            tally_on = 0;
        end else begin
            check(period_start == e_ps, "R2 period strobe", period_start, e_ps);
            check(hi_coarse == e_hi, (e_duty == 0) ? "R4 high side at zero duty" : "R3 high side",
                  hi_coarse, e_hi);
            check(lo_coarse == e_lo, "R6/R8 low side", lo_coarse, e_lo);
            check(!(hi_coarse && lo_coarse), "R7 overlap", hi_coarse & lo_coarse, 0);
            if (period_start) begin
                if (tally_on) begin
                    check(t_hi == t_duty, (t_duty == 0) ? "R4 zero-duty tally" : "R5 high-side tally",
                          t_hi, t_duty);
                    check(t_lo == lo_count(t_duty, t_dead), "R8 low-side tally",
                          t_lo, lo_count(t_duty, t_dead));
                end
                tally_on = 1; t_hi = 0; t_lo = 0; t_duty = e_duty; t_dead = e_dead;
            end
            if (tally_on) begin
                t_hi += int'(hi_coarse);
                t_lo += int'(lo_coarse);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(int d, int t);
        duty_msb    = CW'(d);
        dead_cycles = DW'(t);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_cfg(12, 2);
        tick(4);
        rst_n = 1'b1;
        // Directed corners, each held for two full periods.
        set_cfg(0, 0);        tick(2 * PER_LEN);   // R4, R6 complement
        set_cfg(31, 0);       tick(2 * PER_LEN);   // max duty
        set_cfg(16, 3);       tick(2 * PER_LEN);   // R6 guard
        set_cfg(10, 15);      tick(2 * PER_LEN);   // D+T past the period end
        set_cfg(0, 15);       tick(2 * PER_LEN);
        set_cfg(31, 15);      tick(2 * PER_LEN);
        // R5/R8: mid-period changes must wait for the next wrap.
        set_cfg(20, 1);       tick(PER_LEN + 7);
        set_cfg(3, 9);        tick(5);
        set_cfg(27, 0);       tick(3 * PER_LEN);
        // Constrained random: occasional changes at any position.
        for (int c = 0; c < 60 * PER_LEN; c++) begin
            if ($urandom_range(7) == 0) begin
                int d, t;
                case ($urandom_range(3))
                    0: d = 0;
                    1: d = PER_LEN - 1;
                    default: d = $urandom_range(PER_LEN - 1);
                endcase
                t = ($urandom_range(3) == 0) ? $urandom_range(15) : $urandom_range(3);
                set_cfg(d, t);
            end
            tick(1);
        end
        // Reset in mid-run, then recover.
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; set_cfg(5, 2); tick(3 * PER_LEN);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule